// File: doc/BRIEF.md
# Flash Embedded-Operation Status Byte Generator

This block builds the byte a flash memory returns on its data pins while an embedded byte program or erase is running, or while a sector erase is suspended. While nothing is running it passes array data through unchanged. While an operation runs, the block replaces the array data with a status byte. That byte holds a polling bit, two toggle bits, an error bit and an erase-timer bit. Host software finds out how far the operation has progressed by reading this byte again and again.

The array, the command decoder and the program/erase pulse timers sit outside the block. It receives the busy state, the operation kind, the last programmed byte, the erase target, the read address, a timeout flag and an active-low read strobe. A start pulse marks each new operation. A protected-target flag at that start makes the block itself show a short, parameter-sized run of status. After that run the block returns to read mode.

Top module: `flash_status_gen`

## Requirements
- R1: When no operation is active (busy low, protected window expired) and no erase is suspended, `dq_out` equals `array_data`.
- R2: During an active byte program, `dq_out[7]` is the inverse of `prog_data[7]`, bit 6 is the toggle state, bit 5 is `timeout`, and bits 4..0 are 0.
- R3: During an active erase, `dq_out[7]` is 0, bit 3 is 1, bit 2 is the sector toggle state, bit 5 is `timeout`, and bits 4, 1 and 0 are 0.
- R4: While an operation is active and not suspended, bit 6 inverts once for every falling edge of `rd_n`, at any address. A falling edge is a clock where `rd_n` is 0 after being 1 on the previous clock. Bit 6 holds its value when there are no reads.
- R5: `timeout` high during an operation sets bit 5, and bit 6 keeps toggling.
- R6: In a sector erase, bit 2 inverts only on read falling edges whose sector field (`rd_addr[ADDR_W-1 -: SECT_W]`) equals `erase_sector`. In a chip erase (`erase_chip`=1), bit 2 inverts on every read.
- R7: While `suspended` is high, a read inside the erased sector returns {1, bit 6 frozen, 0, 0, 0, bit 2, 0, 0}, and bit 2 still inverts on each such read. A read from any other sector returns `array_data`.
- R8: An `op_start` pulse clears both toggle states to 0.
- R9: `op_start` with `all_prot`=1 and `op_erase`=0 shows active status for exactly PROT_PROG_CYC clocks after that edge, then returns to R1, with no `busy` input needed.
- R10: `op_start` with `all_prot`=1 and `op_erase`=1 shows active status for PROT_ERASE_CYC clocks, then returns to R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Embedded operation running |
| op_erase | input | 1 | 1 = erase, 0 = byte program |
| erase_chip | input | 1 | 1 = whole-chip erase, 0 = single sector |
| suspended | input | 1 | Sector erase suspended |
| op_start | input | 1 | One-clock pulse at the start of an operation |
| all_prot | input | 1 | All targeted sectors protected (sampled with op_start) |
| prog_data | input | 8 | Last byte written for programming |
| erase_sector | input | SECT_W | Sector under erase |
| rd_addr | input | ADDR_W | Read address |
| rd_n | input | 1 | Active-low read strobe |
| timeout | input | 1 | Time limit exceeded |
| array_data | input | 8 | Data read from the array |
| dq_out | output | 8 | Byte returned to the host |

## Verification
The bench first drives idle reads, then a program with a flipping data bit 7, then sector erases read from inside and outside the target sector, then a chip erase read at scattered addresses. These sequences separate the polling rule from the two toggle rules and show that the toggles depend on the address. Suspend reads split between the erased sector and the other sectors, which shows that bit 6 freezes while bit 2 keeps toggling. Both protected windows run to expiry, which checks each duration and the return to passthrough. A reference model compares every clock against the design, and additional checks confirm the toggle counts, the start clear and the timeout bit.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int ADDR_W         = 18,
  parameter int SECT_W         = 3,
  parameter int PROT_PROG_CYC  = 200,
  parameter int PROT_ERASE_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              op_erase,
  input  logic              erase_chip,
  input  logic              suspended,
  input  logic              op_start,
  input  logic              all_prot,
  input  logic [7:0]        prog_data,
  input  logic [SECT_W-1:0] erase_sector,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_n,
  input  logic              timeout,
  input  logic [7:0]        array_data,
  output logic [7:0]        dq_out
);
  localparam int MAXC  = (PROT_ERASE_CYC > PROT_PROG_CYC) ? PROT_ERASE_CYC : PROT_PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic              rd_q, tog6, tog2;
  logic [CNT_W-1:0]  pcnt;

  wire rd_fall = rd_q & ~rd_n;
  wire prot_on = pcnt != '0;
  wire active  = busy | prot_on;
  wire running = active & ~suspended;
  wire in_sect = rd_addr[ADDR_W-1 -: SECT_W] == erase_sector;
  wire t2_hit  = (running & op_erase & (erase_chip | in_sect)) | (suspended & in_sect);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_q <= 1'b1;
    else        rd_q <= rd_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (op_start) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (rd_fall) begin
      if (running) tog6 <= ~tog6;
      if (t2_hit)  tog2 <= ~tog2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    pcnt <= '0;
    else if (op_start && all_prot) pcnt <= op_erase ? CNT_W'(PROT_ERASE_CYC) : CNT_W'(PROT_PROG_CYC);
    else if (prot_on)              pcnt <= pcnt - 1'b1;

  always_comb begin
    dq_out = array_data;
    if (suspended) begin
      if (in_sect) dq_out = {1'b1, tog6, 3'b000, tog2, 2'b00};
    end else if (active) begin
      dq_out    = '0;
      dq_out[6] = tog6;
      dq_out[5] = timeout;
      if (op_erase) begin
        dq_out[3] = 1'b1;
        dq_out[2] = tog2;
      end else begin
        dq_out[7] = ~prog_data[7];
      end
    end
  end

  // R4
  tog6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fall && !op_start) |=> $stable(tog6));
  // R4
  tog6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && running && !op_start) |=> (tog6 != $past(tog6)));
  // R2
  poll_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !op_erase) |-> (dq_out[7] != prog_data[7]));
  // R3
  poll_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && op_erase) |-> (dq_out[7] == 1'b0 && dq_out[3]));
  // R6
  sect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && !suspended && op_erase && !erase_chip && !in_sect) |=> $stable(tog2));
  // R9
  prot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !op_start) |=> (pcnt == $past(pcnt) - 1'b1));
  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !prot_on && !suspended) |-> (dq_out == array_data));
endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int AW = 18, SW = 3, PP = 200, PE = 10000;

  logic clk = 0, rst_n = 0;
  logic busy = 0, op_erase = 0, erase_chip = 0, suspended = 0, op_start = 0, all_prot = 0;
  logic [7:0] prog_data = 8'h00;
  logic [SW-1:0] erase_sector = '0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_n = 1, timeout = 0;
  logic [7:0] array_data, dq_out;

  assign array_data = rd_addr[7:0] ^ {rd_addr[AW-1 -: SW], 5'h15};

  flash_status_gen #(.ADDR_W(AW), .SECT_W(SW), .PROT_PROG_CYC(PP), .PROT_ERASE_CYC(PE)) i_flash_status_gen (
    .clk, .rst_n, .busy, .op_erase, .erase_chip, .suspended, .op_start, .all_prot,
    .prog_data, .erase_sector, .rd_addr, .rd_n, .timeout, .array_data, .dq_out);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int m_t6 = 0, m_t2 = 0, m_cnt = 0, m_prev = 1;
  bit done = 0;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: dq_out=%h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t6 = 0; m_t2 = 0; m_cnt = 0; m_prev = 1;
    end else begin
      automatic bit fell = (m_prev == 1) && (rd_n == 0);
      automatic bit act = busy || (m_cnt > 0);
      automatic bit same = rd_addr[AW-1 -: SW] == erase_sector;
      if (op_start) begin
        m_t6 = 0; m_t2 = 0;
      end else if (fell) begin
        if (act && !suspended) m_t6 = 1 - m_t6;
        if ((act && !suspended && op_erase && (erase_chip || same)) || (suspended && same)) m_t2 = 1 - m_t2;
      end
      if (op_start && all_prot) m_cnt = op_erase ? PE : PP;
      else if (m_cnt > 0) m_cnt--;
      m_prev = rd_n;
    end
    #3;
    if (rst_n) begin
      automatic logic [7:0] e = array_data;
      automatic string tag = "R1";
      automatic bit same2 = rd_addr[AW-1 -: SW] == erase_sector;
      if (suspended) begin
        tag = "R7";
        if (same2) e = {1'b1, m_t6[0], 3'b000, m_t2[0], 2'b00};
      end else if (busy || m_cnt > 0) begin
        if (op_erase) begin tag = "R3"; e = {1'b0, m_t6[0], timeout, 2'b01, m_t2[0], 2'b00}; end
        else begin tag = "R2"; e = {~prog_data[7], m_t6[0], timeout, 5'b0}; end
      end
      chk(tag, dq_out, e);
    end
  end

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_addr = a; rd_n = 0;
    @(negedge clk);
    @(negedge clk); rd_n = 1;
  endtask

  task automatic start(input bit er, input bit chip, input bit prot, input bit b);
    @(negedge clk); op_erase = er; erase_chip = chip; all_prot = prot; op_start = 1; busy = b;
    @(negedge clk); op_start = 0; all_prot = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", dq_out, array_data);
    rst_n = 1;
    rd(18'h0_1234); rd(18'h3_00FF);
    @(negedge clk); chk("R1 idle", dq_out, array_data);

    // program, bit7 of data = 1
    prog_data = 8'hA5;
    start(0, 0, 0, 1);
    @(negedge clk); chk("R8 start clear", dq_out, 8'h00);
    for (int i = 1; i <= 5; i++) begin
      rd(18'(i * 18'h0_9173));
      chk("R4 toggle count", {7'b0, dq_out[6]}, 8'(i % 2));
    end
    repeat (4) @(negedge clk); chk("R4 hold", {7'b0, dq_out[6]}, 8'h01);
    timeout = 1; rd(18'h2_0000);
    chk("R5 timeout", dq_out, 8'h20);
    timeout = 0;
    prog_data = 8'h3C; @(negedge clk);
    chk("R2 polling", dq_out, 8'h80);
    busy = 0; @(negedge clk); chk("R1 done", dq_out, array_data);

    // sector erase on sector 5
    erase_sector = 3'd5;
    start(1, 0, 0, 1);
    rd({3'd2, 15'h0100}); rd({3'd7, 15'h0100});
    chk("R6 outside sector", {7'b0, dq_out[2]}, 8'h00);
    rd({3'd5, 15'h7FFF});
    chk("R6 inside sector", {7'b0, dq_out[2]}, 8'h01);
    chk("R3 erase status", dq_out, 8'h4C);
    // suspend
    suspended = 1;
    rd({3'd5, 15'h0001});
    chk("R7 suspended sector", dq_out, 8'hC0);
    rd({3'd1, 15'h0001});
    chk("R7 other sector", dq_out, array_data);
    suspended = 0; rd({3'd0, 15'h0002});
    busy = 0;

    // chip erase
    start(1, 1, 0, 1);
    rd({3'd0, 15'h0}); rd({3'd3, 15'h1}); rd({3'd6, 15'h2});
    chk("R6 chip erase", dq_out, 8'h4C);
    busy = 0;

    // protected program
    prog_data = 8'h01;
    start(0, 0, 1, 0);
    repeat (100) @(negedge clk);
    chk("R9 protected status", dq_out, 8'h80);
    rd(18'h0_0042);
    repeat (100) @(negedge clk);
    chk("R9 window ended", dq_out, array_data);

    // protected erase
    start(1, 0, 1, 0);
    repeat (PE - 50) @(negedge clk);
    chk("R10 protected status", dq_out, 8'h08);
    repeat (60) @(negedge clk);
    chk("R10 window ended", dq_out, array_data);
    done = 1;
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule